// File: doc/BRIEF.md
# Two-Address I2C Target with Paged Register Memory

This block is an I2C target that serves two device addresses from one pair of bus lines. One address reaches a flat 256-byte auxiliary memory. The other reaches a main memory. The main memory has a fixed lower half (00h–7Fh) and an upper half (80h–FFh) that is filled by one of several tables, picked by a page-select byte stored at lower address 7Fh. Each device keeps its own byte pointer. A register-address byte in a write loads the pointer. Every byte that is then written or read advances it.

The bus lines are sampled with the system clock. The block detects START, repeated START and STOP from those samples and acknowledges bytes by pulling SDA low through an open-drain enable. The main device address is either fixed at A2h or taken from a configuration byte held in table 02h, chosen by a strap input. When the programmed main address lands on A0h, the auxiliary memory can no longer be reached.

Top module: `i2c_paged_target`

## Requirements
- R1: After reset the block releases SDA, both pointers read 00h, the page-select byte is 00h, and the configuration byte at table 02h offset 8Ch holds A2h.
- R2: With the strap low, an address byte whose upper seven bits match A0h selects the auxiliary memory and one matching A2h selects the main memory. Bit 0 of the address byte is R/W (1 = read). Both forms are ACKed by driving SDA low on the ninth clock.
- R3: An address byte that matches no enabled device is not ACKed, and every later byte up to the next START is neither ACKed nor stored.
- R4: A write (address with R/W=0, register address, data bytes) ACKs every byte and stores successive data bytes at successive addresses starting at the register address.
- R5: A read with no register address returns data from the current pointer value, which is left by the previous transfer to that device.
- R6: A dummy write of a register address followed by a repeated START and a read returns data starting at that register address.
- R7: When the master ACKs a read byte (SDA low on the ninth clock), the next byte follows. After a master NACK the block keeps SDA released until START or STOP.
- R8: Address 7Fh is the page-select byte. With value 01h, 02h or 04h, addresses 80h–FFh read and write that table. With any other value, reads in that range return 00h and writes there are dropped.
- R9: The main pointer advances from 7Fh to 00h and from FFh to 80h. The auxiliary pointer advances from FFh to 00h.
- R10: With the strap high, the main device address is the byte at table 02h offset 8Ch, checked on bits 7:1 at each address byte. The auxiliary memory stays at A0h.
- R11: With the strap high and that byte equal to A0h, A0h/A1h transactions reach the main memory and the auxiliary memory is not reached.
- R12: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. The two are never flagged together. After a STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad (wired-AND of all drivers) |
| addr_sel_i | input | 1 | 0: main device at A2h; 1: main device address from the configuration byte |
| sda_drive_low_o | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The embedded assertions check behaviour that must hold on every cycle. START and STOP are never flagged together. SDA is released after a STOP and throughout an ignored transaction. A new low drive starts only while SCL is low. A pointer advance never leaves its half of the main space. The configuration byte changes only on a write. Byte-level outcomes can only be shown by the bench's scenarios against its behavioural memory model: data landing at successive addresses, the page-select routing, the wrap points, and which device answers after the main address is reprogrammed to A0h.

// File: rtl/i2c_paged_pkg.sv
// Shared constants, state encoding and helper functions for the paged I2C target.
package i2c_paged_pkg;
    localparam int          BYTE_W       = 8;
    localparam int          SPACE_BYTES  = 1 << BYTE_W;
    localparam int          REGION_BYTES = SPACE_BYTES / 2;
    localparam logic [3:0]  BITS_PER_BYTE = 4'(BYTE_W);

    localparam logic [7:0]  AUX_DEV      = 8'hA0;
    localparam logic [7:0]  MAIN_DEV_DEF = 8'hA2;
    localparam logic [6:0]  PAGE_SEL_OFS = 7'h7F;
    localparam logic [7:0]  CFG_TABLE    = 8'h02;
    localparam logic [6:0]  CFG_OFS      = 7'h0C;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_ADDR,
        S_REG,
        S_ACK_REG,
        S_WDATA,
        S_ACK_DATA,
        S_RDATA,
        S_RACK,
        S_IGNORE
    } tgt_state_e;

    // Table number served by generate slot g (01h, 02h, 04h, ...).
    function automatic logic [7:0] table_id(input int g);
        return 8'(1 << g);
    endfunction

    // Main pointer step that stays inside its own half of the space.
    function automatic logic [7:0] main_ptr_next(input logic [7:0] p);
        return {p[7], p[6:0] + 7'd1};
    endfunction
endpackage

// File: rtl/i2c_line_sampler.sv
// Bus line sampler: brings SCL and SDA into the clock domain and flags edges.
// Assumes the bus is idle-high at reset and that the lines are slow against clk.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic [SYNC_STAGES-1:0] scl_sy;
    logic [SYNC_STAGES-1:0] sda_sy;
    logic                   scl_q;
    logic                   sda_q;

    // Synchroniser chains plus one-cycle history of the settled values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s      = scl_sy[SYNC_STAGES-1];
    assign sda_s      = sda_sy[SYNC_STAGES-1];
    assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise_o = scl_s & ~scl_q;
    assign scl_fall_o = ~scl_s & scl_q;

    a_r12_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/i2c_target_fsm.sv
// Byte-level protocol engine: address matching, ACK drive, read shifting and
// the two byte pointers. Assumes the edge flags come from i2c_line_sampler and
// that memory reads are combinational on acc_addr_o.
module i2c_target_fsm
    import i2c_paged_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       addr_sel_i,
    input  logic [7:0] main_cfg_i,
    input  logic [7:0] rd_data_i,
    output logic       wr_en_o,
    output logic [7:0] wr_data_o,
    output logic       acc_aux_o,
    output logic [7:0] acc_addr_o,
    output logic       sda_low_o
);
    tgt_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] aux_ptr;
    logic [7:0] main_ptr;
    logic       is_aux;
    logic       is_read;
    logic       nack_q;
    logic       sda_low_q;

    logic [7:0] main_dev;
    logic       hit_main;
    logic       hit_aux;
    logic       byte_done;
    logic       reg_load;
    logic       ptr_adv;
    logic       shifting;

    // Device decode and per-byte event qualifiers.
    always_comb begin
        main_dev  = addr_sel_i ? main_cfg_i : MAIN_DEV_DEF;
        hit_main  = (shreg[7:1] == main_dev[7:1]);
        hit_aux   = (shreg[7:1] == AUX_DEV[7:1]) && (main_dev[7:1] != AUX_DEV[7:1]);
        byte_done = scl_fall_i && (cnt == BITS_PER_BYTE) && !start_i && !stop_i;
        reg_load  = byte_done && (state == S_REG);
        ptr_adv   = byte_done && ((state == S_WDATA) || (state == S_RDATA));
        shifting  = scl_rise_i && !start_i && !stop_i &&
                    ((state == S_ADDR) || (state == S_REG) || (state == S_WDATA));
    end

    // Protocol state, shift register and open-drain drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            is_aux    <= 1'b0;
            is_read   <= 1'b0;
            nack_q    <= 1'b0;
            sda_low_q <= 1'b0;
        end else if (start_i) begin
            state     <= S_ADDR;
            cnt       <= '0;
            sda_low_q <= 1'b0;
        end else if (stop_i) begin
            state     <= S_IDLE;
            sda_low_q <= 1'b0;
        end else begin
            if (shifting) begin
                shreg <= {shreg[6:0], sda_s};
                cnt   <= cnt + 4'd1;
            end
            case (state)
                S_ADDR: if (byte_done) begin
                    if (hit_main || hit_aux) begin
                        is_aux    <= !hit_main;
                        is_read   <= shreg[0];
                        sda_low_q <= 1'b1;
                        state     <= S_ACK_ADDR;
                    end else begin
                        state <= S_IGNORE;
                    end
                end
                S_ACK_ADDR: if (scl_fall_i) begin
                    if (is_read) begin
                        shreg     <= rd_data_i;
                        sda_low_q <= ~rd_data_i[7];
                        cnt       <= 4'd1;
                        state     <= S_RDATA;
                    end else begin
                        sda_low_q <= 1'b0;
                        cnt       <= '0;
                        state     <= S_REG;
                    end
                end
                S_REG: if (byte_done) begin
                    sda_low_q <= 1'b1;
                    state     <= S_ACK_REG;
                end
                S_WDATA: if (byte_done) begin
                    sda_low_q <= 1'b1;
                    state     <= S_ACK_DATA;
                end
                S_ACK_REG, S_ACK_DATA: if (scl_fall_i) begin
                    sda_low_q <= 1'b0;
                    cnt       <= '0;
                    state     <= S_WDATA;
                end
                S_RDATA: if (scl_fall_i) begin
                    if (cnt == BITS_PER_BYTE) begin
                        sda_low_q <= 1'b0;
                        state     <= S_RACK;
                    end else begin
                        sda_low_q <= ~shreg[6];
                        shreg     <= {shreg[6:0], 1'b0};
                        cnt       <= cnt + 4'd1;
                    end
                end
                S_RACK: begin
                    if (scl_rise_i) begin
                        nack_q <= sda_s;
                    end
                    if (scl_fall_i) begin
                        if (nack_q) begin
                            state <= S_IGNORE;
                        end else begin
                            shreg     <= rd_data_i;
                            sda_low_q <= ~rd_data_i[7];
                            cnt       <= 4'd1;
                            state     <= S_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Byte pointers: loaded by a register-address byte, stepped per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_ptr  <= '0;
            main_ptr <= '0;
        end else if (reg_load) begin
            if (is_aux) aux_ptr  <= shreg;
            else        main_ptr <= shreg;
        end else if (ptr_adv) begin
            if (is_aux) aux_ptr  <= aux_ptr + 8'd1;
            else        main_ptr <= main_ptr_next(main_ptr);
        end
    end

    assign wr_en_o    = byte_done && (state == S_WDATA);
    assign wr_data_o  = shreg;
    assign acc_aux_o  = is_aux;
    assign acc_addr_o = is_aux ? aux_ptr : main_ptr;
    assign sda_low_o  = sda_low_q;

    a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_low_q);
    a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !sda_low_q);
    a_r12_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_q) |-> !scl_s);
    a_r9_main_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && !is_aux) |=> (main_ptr[7] == $past(main_ptr[7])));
endmodule

// File: rtl/paged_regfile.sv
// Register storage: lower half, page tables for the upper half, and the flat
// auxiliary space. Reads are combinational; writes land on wr_en.
// Assumes the page-select byte sits in the lower half and that one table slot
// carries the configuration byte.
module paged_regfile
    import i2c_paged_pkg::*;
#(
    parameter int NUM_TABLES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       acc_aux,
    input  logic [7:0] acc_addr,
    output logic [7:0] rd_data,
    output logic [7:0] main_cfg
);
    logic [7:0]            low_mem [REGION_BYTES];
    logic [7:0]            aux_mem [SPACE_BYTES];
    logic [7:0]            tab_rd  [NUM_TABLES];
    logic [NUM_TABLES-1:0] tbl_hit;
    logic [7:0]            page_sel;
    logic                  wr_low;
    logic                  wr_up;

    assign page_sel = low_mem[PAGE_SEL_OFS];
    assign wr_low   = wr_en && !acc_aux && !acc_addr[7];
    assign wr_up    = wr_en && !acc_aux && acc_addr[7];

    // Lower half storage, including the page-select byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REGION_BYTES; i++) low_mem[i] <= '0;
        end else if (wr_low) begin
            low_mem[acc_addr[6:0]] <= wr_data;
        end
    end

    // Auxiliary device storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SPACE_BYTES; i++) aux_mem[i] <= '0;
        end else if (wr_en && acc_aux) begin
            aux_mem[acc_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_TABLES; g++) begin : g_table
        logic [7:0] mem [REGION_BYTES];

        assign tbl_hit[g] = (page_sel == table_id(g));

        // One upper-half table; the configuration slot resets to the default address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < REGION_BYTES; i++)
                    mem[i] <= (table_id(g) == CFG_TABLE && i == int'(CFG_OFS)) ? MAIN_DEV_DEF : 8'h00;
            end else if (wr_up && tbl_hit[g]) begin
                mem[acc_addr[6:0]] <= wr_data;
            end
        end

        assign tab_rd[g] = mem[acc_addr[6:0]];

        if (table_id(g) == CFG_TABLE) begin : g_cfg
            assign main_cfg = mem[CFG_OFS];
        end
    end

    // Read mux: auxiliary, lower half, or the selected table (00h if none).
    always_comb begin
        rd_data = 8'h00;
        if (acc_aux) begin
            rd_data = aux_mem[acc_addr];
        end else if (!acc_addr[7]) begin
            rd_data = low_mem[acc_addr[6:0]];
        end else begin
            for (int g = 0; g < NUM_TABLES; g++)
                if (tbl_hit[g]) rd_data = tab_rd[g];
        end
    end

    a_r8_cfg_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(main_cfg));
    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_aux && acc_addr[7] && (tbl_hit == '0)) |-> (rd_data == 8'h00));
endmodule

// File: rtl/i2c_paged_target.sv
// Top level: line sampler, protocol engine and paged register storage.
// Assumes SDA is wired-AND outside; sda_drive_low_o is the open-drain enable.
module i2c_paged_target #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_TABLES  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel_i,
    output logic sda_drive_low_o
);
    logic       scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
    logic       wr_en, acc_aux;
    logic [7:0] wr_data, acc_addr, rd_data, main_cfg;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .start_o(start_p), .stop_o(stop_p),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
    );

    i2c_target_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_i(start_p), .stop_i(stop_p), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .addr_sel_i(addr_sel_i), .main_cfg_i(main_cfg), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_data_o(wr_data), .acc_aux_o(acc_aux),
        .acc_addr_o(acc_addr), .sda_low_o(sda_drive_low_o)
    );

    paged_regfile #(.NUM_TABLES(NUM_TABLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .acc_aux(acc_aux), .acc_addr(acc_addr), .rd_data(rd_data), .main_cfg(main_cfg)
    );
endmodule

// File: tb/tb_i2c_paged_target.sv
// Bench: bus master tasks plus a behavioural memory model; every ACK and read
// byte is compared, and SDA is watched on every clock while the DUT must be quiet.
module tb_i2c_paged_target;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sel = 1'b0;
    logic drv;
    logic bus_sda;
    int   compared = 0;
    int   mismatched = 0;
    bit   quiet = 1'b0;

    logic [7:0] m_low [128];
    logic [7:0] m_tab [3][128];
    logic [7:0] m_aux [256];
    logic [7:0] p_main = 8'h00;
    logic [7:0] p_aux = 8'h00;

    assign bus_sda = sda_m & ~drv;

    i2c_paged_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus_sda),
        .addr_sel_i(sel), .sda_drive_low_o(drv)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // R12: per-clock watch of the open-drain enable whenever the DUT must be silent.
    always @(negedge clk) begin
        if (rst_n && quiet) begin
            compared++;
            if (drv !== 1'b0) begin
                mismatched++;
                $display("FAIL R12 quiet bus: actual drive %b expected 0", drv);
            end
        end
    end

    function automatic int tidx(input logic [7:0] t);
        if (t == 8'h01) return 0;
        if (t == 8'h02) return 1;
        if (t == 8'h04) return 2;
        return -1;
    endfunction

    // 0 = nobody answers, 1 = auxiliary, 2 = main.
    function automatic int who(input logic [7:0] a);
        logic [7:0] md;
        md = sel ? m_tab[1][12] : 8'hA2;
        if (a[7:1] == md[7:1]) return 2;
        if (a[7:1] == 7'h50 && md[7:1] != 7'h50) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] m_read(input int t);
        int k;
        if (t == 1) return m_aux[p_aux];
        if (p_main < 8'h80) return m_low[p_main[6:0]];
        k = tidx(m_low[127]);
        if (k < 0) return 8'h00;
        return m_tab[k][p_main[6:0]];
    endfunction

    task automatic m_write(input int t, input logic [7:0] d);
        int k;
        if (t == 1) m_aux[p_aux] = d;
        else if (p_main < 8'h80) m_low[p_main[6:0]] = d;
        else begin
            k = tidx(m_low[127]);
            if (k >= 0) m_tab[k][p_main[6:0]] = d;
        end
    endtask

    task automatic m_step(input int t);
        if (t == 1) p_aux = p_aux + 8'd1;
        else if (p_main == 8'h7F) p_main = 8'h00;
        else if (p_main == 8'hFF) p_main = 8'h80;
        else p_main = p_main + 8'd1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; tick(H);
        quiet = 1'b0;
        sda_m = 1'b0; tick(H);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
        quiet = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl = 1'b1; tick(H);
            scl = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(H);
        scl = 1'b1; tick(H / 2);
        acked = !bus_sda;
        tick(H / 2);
        scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl = 1'b1; tick(H / 2);
            b[i] = bus_sda;
            tick(H / 2);
            scl = 1'b0; tick(2);
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(H);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] ra, input int n,
                            input logic [7:0] d [4], input string req);
        int t;
        bit a;
        t = who(dev);
        bus_start();
        send_byte({dev[7:1], 1'b0}, a);
        chk(req, "address ack", {7'd0, a}, {7'd0, t != 0});
        if (t == 0) begin
            quiet = 1'b1;
            send_byte(ra, a);
            chk(req, "ignored byte ack", {7'd0, a}, 8'h00);
            for (int i = 0; i < n; i++) begin
                send_byte(d[i], a);
                chk(req, "ignored byte ack", {7'd0, a}, 8'h00);
            end
            bus_stop();
            return;
        end
        send_byte(ra, a);
        chk(req, "register ack", {7'd0, a}, 8'h01);
        if (t == 1) p_aux = ra; else p_main = ra;
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);
            chk(req, "data ack", {7'd0, a}, 8'h01);
            m_write(t, d[i]);
            m_step(t);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] dev, input bit dummy, input logic [7:0] ra,
                           input int n, input string req);
        int t;
        bit a;
        logic [7:0] b;
        t = who(dev);
        bus_start();
        if (dummy) begin
            send_byte({dev[7:1], 1'b0}, a);
            chk(req, "dummy address ack", {7'd0, a}, 8'h01);
            send_byte(ra, a);
            chk(req, "dummy register ack", {7'd0, a}, 8'h01);
            if (t == 1) p_aux = ra; else p_main = ra;
            bus_rstart();
        end
        send_byte({dev[7:1], 1'b1}, a);
        chk(req, "read address ack", {7'd0, a}, 8'h01);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(req, "read data", b, m_read(t));
            m_step(t);
            if (i == n - 1) quiet = 1'b1;
        end
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            m_low[i] = 8'h00;
            for (int k = 0; k < 3; k++) m_tab[k][i] = 8'h00;
        end
        for (int i = 0; i < 256; i++) m_aux[i] = 8'h00;
        m_tab[1][12] = 8'hA2;

        tick(5);
        rst_n = 1'b1;
        tick(3);
        quiet = 1'b1;
        chk("R1", "drive after reset", {7'd0, drv}, 8'h00);
        do_read(8'hA2, 1'b0, 8'h00, 1, "R1");

        do_write(8'hA2, 8'h10, 4, '{8'h11, 8'h22, 8'h33, 8'h44}, "R4");
        do_read(8'hA2, 1'b1, 8'h10, 3, "R6");   // last byte NACKed: R7
        do_read(8'hA2, 1'b0, 8'h00, 1, "R5");   // continues at 13h -> 44h
        do_read(8'hA2, 1'b1, 8'h11, 2, "R7");   // master ACK then NACK

        do_write(8'hA0, 8'h05, 2, '{8'h5A, 8'h6B, 8'h00, 8'h00}, "R2");
        do_read(8'hA0, 1'b1, 8'h05, 2, "R2");
        do_read(8'hA2, 1'b1, 8'h05, 1, "R2");   // main 05h untouched

        do_write(8'h50, 8'h10, 2, '{8'hEE, 8'hEE, 8'h00, 8'h00}, "R3");
        do_read(8'hA2, 1'b1, 8'h10, 2, "R3");

        do_write(8'hA2, 8'h7E, 3, '{8'hAA, 8'h01, 8'h0C, 8'h00}, "R9");
        do_read(8'hA2, 1'b1, 8'h7E, 3, "R9");
        do_write(8'hA2, 8'hFE, 3, '{8'h91, 8'h92, 8'h93, 8'h00}, "R9");
        do_read(8'hA2, 1'b1, 8'hFE, 3, "R9");

        do_write(8'hA2, 8'h7F, 1, '{8'h02, 8'h00, 8'h00, 8'h00}, "R8");
        do_write(8'hA2, 8'h80, 1, '{8'hC2, 8'h00, 8'h00, 8'h00}, "R8");
        do_write(8'hA2, 8'h7F, 1, '{8'h04, 8'h00, 8'h00, 8'h00}, "R8");
        do_write(8'hA2, 8'h80, 2, '{8'hC4, 8'hC5, 8'h00, 8'h00}, "R8");
        do_write(8'hA2, 8'h7F, 1, '{8'h03, 8'h00, 8'h00, 8'h00}, "R8");
        do_write(8'hA2, 8'h80, 1, '{8'hEE, 8'h00, 8'h00, 8'h00}, "R8");
        do_read(8'hA2, 1'b1, 8'h80, 2, "R8");
        do_write(8'hA2, 8'h7F, 1, '{8'h01, 8'h00, 8'h00, 8'h00}, "R8");
        do_read(8'hA2, 1'b1, 8'h80, 1, "R8");
        do_write(8'hA2, 8'h7F, 1, '{8'h04, 8'h00, 8'h00, 8'h00}, "R8");
        do_read(8'hA2, 1'b1, 8'h80, 2, "R8");

        do_write(8'hA0, 8'hFF, 2, '{8'h01, 8'h02, 8'h00, 8'h00}, "R9");
        do_read(8'hA0, 1'b1, 8'hFF, 2, "R9");

        sel = 1'b1;
        do_write(8'hA2, 8'h7F, 1, '{8'h02, 8'h00, 8'h00, 8'h00}, "R10");
        do_read(8'hA2, 1'b1, 8'h8C, 1, "R1");   // configuration byte resets to A2h
        do_write(8'hA2, 8'h8C, 1, '{8'hB4, 8'h00, 8'h00, 8'h00}, "R10");
        do_write(8'hA2, 8'h20, 1, '{8'h77, 8'h00, 8'h00, 8'h00}, "R10");
        do_write(8'hB4, 8'h20, 1, '{8'h66, 8'h00, 8'h00, 8'h00}, "R10");
        do_read(8'hB4, 1'b1, 8'h20, 1, "R10");
        do_read(8'hA0, 1'b1, 8'h05, 1, "R10");

        do_write(8'hB4, 8'h8C, 1, '{8'hA0, 8'h00, 8'h00, 8'h00}, "R11");
        do_write(8'hA0, 8'h30, 1, '{8'h3C, 8'h00, 8'h00, 8'h00}, "R11");
        do_read(8'hA0, 1'b1, 8'h30, 1, "R11");
        sel = 1'b0;
        do_read(8'hA0, 1'b1, 8'h30, 1, "R11");  // auxiliary 30h never written
        do_read(8'hA2, 1'b1, 8'h30, 1, "R11");

        tick(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule